// File: doc/BRIEF.md
# Nibble-Loaded Address Register with Stack Memory

This block is a small digit store: 256 words of 4 bits, each word holding one BCD digit. A single 8-bit address register does two jobs. It is the random-access address for plain reads and writes, and it is also the stack pointer for push and pop. There is no second pointer, so a program that mixes the two kinds of access shares one position in memory.

The register is loaded over the same 4-bit data path as the memory, one nibble per strobe. One strobe places the data word in the lower four address bits and another places it in the upper four. The register can also step up or down by one, and it wraps modulo 256. A push stores the data word at the current address and then advances. A pop first steps back and then reads the word at the new address. Read data comes from a register and appears on the output one clock after the read or pop command, then holds until the next one.

When several commands arrive in the same cycle, exactly one runs, picked by a fixed priority order. All other commands in that cycle have no effect.

Top module: `nibble_stack_ram`

## Requirements
- R1: After reset the address output is 0x00 and the data output is 0.
- R2: `ld_lo` copies `din` into address bits [3:0] and leaves bits [7:4] unchanged. `ld_hi` copies `din` into bits [7:4] and leaves bits [3:0] unchanged. When both strobes are high, only `ld_lo` acts.
- R3: `inc` adds one to the address modulo 256, so 0xFF becomes 0x00. `dec` subtracts one modulo 256, so 0x00 becomes 0xFF. When both are high, `inc` wins.
- R4: `wr` stores `din` at the current address. `rd` places the word at the current address on `dout` one clock later. Neither changes the address.
- R5: `push` stores `din` at the current address, and the address then becomes the old address plus one, modulo 256.
- R6: `pop` makes the address the old address minus one, modulo 256. One clock later `dout` shows the word stored at that new address.
- R7: Only one command runs per cycle, chosen in this priority order:
  - nibble load
  - push
  - pop
  - inc
  - dec
  - wr
  - rd

  Every lower-priority command in that cycle has no effect on the address, the memory or `dout`.
- R8: `dout` keeps its value in every cycle in which neither a read nor a pop runs.
- R9: Each of the 256 addresses holds its own 4-bit word. A write to one address leaves every other address unchanged.
- R10: A run of pushes followed by the same number of pops returns the pushed words in reverse order, including a run that wraps across address 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 4 | Data word, also the address nibble for loads |
| ld_lo | input | 1 | Load `din` into the low address nibble |
| ld_hi | input | 1 | Load `din` into the high address nibble |
| inc | input | 1 | Increment the address |
| dec | input | 1 | Decrement the address |
| wr | input | 1 | Write `din` at the address |
| rd | input | 1 | Read the word at the address |
| push | input | 1 | Write at the address, then increment |
| pop | input | 1 | Decrement, then read |
| dout | output | 4 | Registered read data |
| addr | output | 8 | Current address and stack pointer |

## Verification
The collision that matters most is a pointer-moving command meeting a memory access in the same cycle. Examples are a nibble load arriving together with a push, or an increment arriving together with a pop. In each case the pointer must move once and the memory or `dout` must change only for the winner.

The memory is first filled completely by a wrapping push run, so every address holds a known word. Then each of the 256 subsets of the eight command inputs is driven for one cycle from a known pointer. The pointer and `dout` are compared with a reference computed in the bench from the priority order, and later reads reveal any stray write.

// File: rtl/nsm_pkg.sv
package nsm_pkg;

   // One operation is selected per clock cycle.
   typedef enum logic [2:0] {
      OP_IDLE  = 3'd0,
      OP_LOAD  = 3'd1,
      OP_PUSH  = 3'd2,
      OP_POP   = 3'd3,
      OP_INC   = 3'd4,
      OP_DEC   = 3'd5,
      OP_WRITE = 3'd6,
      OP_READ  = 3'd7
   } nsm_op_e;

endpackage

// File: rtl/nsm_arb.sv
module nsm_arb
   import nsm_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic [LANES-1:0] load_req,
   input  logic             push,
   input  logic             pop,
   input  logic             inc,
   input  logic             dec,
   input  logic             wr,
   input  logic             rd,
   output nsm_op_e          op,
   output logic [LANES-1:0] load_sel
);

   // The lowest-numbered requesting lane wins among the nibble loads.
   assign load_sel = load_req & (~load_req + 1'b1);

   always_comb begin
      if (|load_req)  op = OP_LOAD;
      else if (push)  op = OP_PUSH;
      else if (pop)   op = OP_POP;
      else if (inc)   op = OP_INC;
      else if (dec)   op = OP_DEC;
      else if (wr)    op = OP_WRITE;
      else if (rd)    op = OP_READ;
      else            op = OP_IDLE;
   end

endmodule

// File: rtl/nsm_ptr.sv
module nsm_ptr
   import nsm_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int NIB_W  = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  nsm_op_e                       op,
   input  logic [(ADDR_W/NIB_W)-1:0]     load_sel,
   input  logic [NIB_W-1:0]              nib,
   output logic [ADDR_W-1:0]             addr,
   output logic [ADDR_W-1:0]             addr_dn
);

   localparam int LANES = ADDR_W / NIB_W;

   logic [ADDR_W-1:0] addr_up;
   logic [ADDR_W-1:0] loaded;
   logic [ADDR_W-1:0] addr_nx;

   // Unsigned ADDR_W-bit arithmetic wraps on its own.
   assign addr_up = addr + 1'b1;
   assign addr_dn = addr - 1'b1;

   // Each lane either takes the new nibble or keeps its current bits.
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign loaded[g*NIB_W +: NIB_W] = load_sel[g] ? nib : addr[g*NIB_W +: NIB_W];
   end

   always_comb begin
      case (op)
         OP_LOAD:         addr_nx = loaded;
         OP_PUSH, OP_INC: addr_nx = addr_up;
         OP_POP,  OP_DEC: addr_nx = addr_dn;
         default:         addr_nx = addr;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr <= '0;
      else        addr <= addr_nx;
   end

endmodule

// File: rtl/nsm_store.sv
module nsm_store #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic              we,
   input  logic [ADDR_W-1:0] a,
   input  logic [DATA_W-1:0] wd,
   output logic [DATA_W-1:0] rd_q
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // The array has no reset; a write needs both the enable and the write select.
   always_ff @(posedge clk) begin
      if (ce && we) mem[a] <= wd;
   end

   // A read is the enable with the write select low; the result is registered.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           rd_q <= '0;
      else if (ce && !we)   rd_q <= mem[a];
   end

endmodule

// File: rtl/nibble_stack_ram.sv
module nibble_stack_ram
   import nsm_pkg::*;
#(
   parameter int DATA_W = 4,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   input  logic              ld_lo,
   input  logic              ld_hi,
   input  logic              inc,
   input  logic              dec,
   input  logic              wr,
   input  logic              rd,
   input  logic              push,
   input  logic              pop,
   output logic [DATA_W-1:0] dout,
   output logic [ADDR_W-1:0] addr
);

   localparam int LANES = ADDR_W / DATA_W;

   // The address is built from exactly two data-width nibbles.
   if (LANES != 2 || ADDR_W % DATA_W != 0) begin : g_bad_widths
      $error("nibble_stack_ram: ADDR_W must equal twice DATA_W");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("nibble_stack_ram: DATA_W must be positive");
   end

   nsm_op_e           op;
   logic [LANES-1:0]  load_sel;
   logic [ADDR_W-1:0] addr_dn;
   logic              mem_ce;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_a;

   nsm_arb #(.LANES(LANES)) u_arb (
      .load_req (LANES'({ld_hi, ld_lo})),
      .push     (push),
      .pop      (pop),
      .inc      (inc),
      .dec      (dec),
      .wr       (wr),
      .rd       (rd),
      .op       (op),
      .load_sel (load_sel)
   );

   nsm_ptr #(.ADDR_W(ADDR_W), .NIB_W(DATA_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .load_sel (load_sel),
      .nib      (din),
      .addr     (addr),
      .addr_dn  (addr_dn)
   );

   // Push and write go to the current address.
   // Pop reads at the address it is stepping back to.
   always_comb begin
      mem_ce = 1'b0;
      mem_we = 1'b0;
      mem_a  = addr;
      case (op)
         OP_PUSH, OP_WRITE: begin mem_ce = 1'b1; mem_we = 1'b1; end
         OP_READ:           begin mem_ce = 1'b1; end
         OP_POP:            begin mem_ce = 1'b1; mem_a = addr_dn; end
         default:           ;
      endcase
   end

   nsm_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .ce    (mem_ce),
      .we    (mem_we),
      .a     (mem_a),
      .wd    (din),
      .rd_q  (dout)
   );

endmodule

// File: rtl/nsm_chk.sv
module nsm_chk #(
   parameter int DATA_W = 4,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] din,
   input logic              ld_lo,
   input logic              ld_hi,
   input logic              inc,
   input logic              dec,
   input logic              wr,
   input logic              rd,
   input logic              push,
   input logic              pop,
   input logic [DATA_W-1:0] dout,
   input logic [ADDR_W-1:0] addr
);

   logic any_ld;
   assign any_ld = ld_lo | ld_hi;

   AST_LO_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      ld_lo |=> (addr[DATA_W-1:0] == $past(din)) &&
                (addr[ADDR_W-1:DATA_W] == $past(addr[ADDR_W-1:DATA_W]))); // R2

   AST_HI_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_hi && !ld_lo) |=> (addr[ADDR_W-1:DATA_W] == $past(din)) &&
                            (addr[DATA_W-1:0] == $past(addr[DATA_W-1:0]))); // R2

   AST_PUSH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !any_ld) |=> addr == ADDR_W'($past(addr) + 1'b1)); // R5

   AST_POP_RETREAT: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !any_ld && !push) |=> addr == ADDR_W'($past(addr) - 1'b1)); // R6

   AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !any_ld && !push && !pop) |=> addr == ADDR_W'($past(addr) + 1'b1)); // R3

   AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc && !any_ld && !push && !pop) |=> addr == ADDR_W'($past(addr) - 1'b1)); // R3

   AST_ACCESS_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr || rd) && !any_ld && !push && !pop && !inc && !dec) |=> $stable(addr)); // R4

   AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd && !pop) |=> $stable(dout)); // R8

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_ld && !push && !pop && !inc && !dec) |=> $stable(addr)); // R7

endmodule

bind nibble_stack_ram nsm_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .din   (din),
   .ld_lo (ld_lo),
   .ld_hi (ld_hi),
   .inc   (inc),
   .dec   (dec),
   .wr    (wr),
   .rd    (rd),
   .push  (push),
   .pop   (pop),
   .dout  (dout),
   .addr  (addr)
);

// File: tb/nibble_stack_ram_tb.sv
`timescale 1ns/1ps
module nibble_stack_ram_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] din = '0;
   logic       ld_lo = 0, ld_hi = 0, inc = 0, dec = 0, wr = 0, rd = 0, push = 0, pop = 0;
   logic [3:0] dout;
   logic [7:0] addr;

   int checks = 0;
   int errors = 0;

   // Reference state, computed from the requirements.
   logic [3:0] ref_mem [256];
   logic [7:0] ref_addr = 8'h00;
   logic [3:0] ref_dout = 4'h0;

   always #2.5 clk = ~clk;

   nibble_stack_ram u_dut (
      .clk(clk), .rst_n(rst_n), .din(din),
      .ld_lo(ld_lo), .ld_hi(ld_hi), .inc(inc), .dec(dec),
      .wr(wr), .rd(rd), .push(push), .pop(pop),
      .dout(dout), .addr(addr)
   );

   task automatic check_outputs(input string tag);
      checks++;
      if (addr !== ref_addr) begin
         errors++;
         $display("FAIL %s addr actual=%h expected=%h", tag, addr, ref_addr);
      end
      checks++;
      if (dout !== ref_dout) begin
         errors++;
         $display("FAIL %s dout actual=%h expected=%h", tag, dout, ref_dout);
      end
   endtask

   // cmd bits: [0]ld_lo [1]ld_hi [2]push [3]pop [4]inc [5]dec [6]wr [7]rd
   task automatic step(input logic [7:0] cmd, input logic [3:0] d, input string tag);
      ld_lo = cmd[0]; ld_hi = cmd[1]; push = cmd[2]; pop = cmd[3];
      inc = cmd[4]; dec = cmd[5]; wr = cmd[6]; rd = cmd[7];
      din = d;
      if (cmd[0])      ref_addr[3:0] = d;
      else if (cmd[1]) ref_addr[7:4] = d;
      else if (cmd[2]) begin ref_mem[ref_addr] = d; ref_addr = ref_addr + 8'd1; end
      else if (cmd[3]) begin ref_addr = ref_addr - 8'd1; ref_dout = ref_mem[ref_addr]; end
      else if (cmd[4]) ref_addr = ref_addr + 8'd1;
      else if (cmd[5]) ref_addr = ref_addr - 8'd1;
      else if (cmd[6]) ref_mem[ref_addr] = d;
      else if (cmd[7]) ref_dout = ref_mem[ref_addr];
      @(posedge clk);
      @(negedge clk);
      {ld_lo, ld_hi, push, pop, inc, dec, wr, rd} = '0;
      check_outputs(tag);
   endtask

   task automatic set_addr(input logic [7:0] a);
      step(8'h01, a[3:0], "R2");
      step(8'h02, a[7:4], "R2");
   endtask

   initial begin
      #(100000 * 5);
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_outputs("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_outputs("R1");

      // R5 R10: fill all 256 words by a push run starting at 0x10; it wraps past 0xFF.
      set_addr(8'h10);
      for (int i = 0; i < 256; i++) step(8'h04, 4'((i * 5 + 1) & 15), "R5");
      // R6 R10: pop the whole run back, newest first.
      for (int i = 0; i < 256; i++) step(8'h08, 4'h0, "R10");

      // R6 boundary: pop from 0x00 reads 0xFF.
      set_addr(8'h00);
      step(8'h08, 4'h0, "R6");
      // R5 boundary: push at 0xFF wraps to 0x00.
      step(8'h04, 4'h9, "R5");

      // R3: inc and dec wrap both ways; inc wins over dec.
      set_addr(8'hFF);
      step(8'h10, 4'h0, "R3");
      step(8'h20, 4'h0, "R3");
      step(8'h30, 4'h0, "R3");

      // R2: both strobes at once load only the low nibble.
      step(8'h03, 4'hA, "R2");

      // R4 R9: random-access write of every address, then read every address.
      for (int a = 0; a < 256; a++) begin
         set_addr(8'(a));
         step(8'h40, 4'((a ^ (a >> 4) ^ 4'h6) & 15), "R9");
      end
      for (int a = 255; a >= 0; a--) begin
         set_addr(8'(a));
         step(8'h80, 4'h0, "R4");
         step(8'h00, 4'h0, "R8");
      end

      // R7: every combination of the eight commands from a known pointer.
      for (int c = 0; c < 256; c++) begin
         set_addr(8'(c * 37 + 5));
         step(8'(c), 4'((c * 3 + 7) & 15), "R7");
         step(8'h80, 4'h0, "R7");
      end

      // R8: idle cycles keep dout and the pointer.
      for (int i = 0; i < 4; i++) step(8'h00, 4'(i), "R8");

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule